// File: doc/BRIEF.md
# Indexed Load/Store Address Unit with Base Update

This unit sits between a 32-bit big-endian integer pipeline and a simple synchronous data memory port. For each indexed byte, half-word or word access it forms the effective address from two register values, drives the memory request with byte-lane enables and lane-aligned store data, and then turns the returned read word into a right-justified, zero- or sign-extended value for the destination register. For the with-update forms it also issues a base-register writeback of the effective address.

The read data arrives one cycle after the request, so loads pass through a two-state machine. `S_IDLE` is the state with no load result pending. `S_LOAD_WAIT` is the state in which a load result is written back. The transitions are:

- `T_ISSUE`: `S_IDLE` to `S_LOAD_WAIT`, when a load is accepted.
- `T_CHAIN`: `S_LOAD_WAIT` to `S_LOAD_WAIT`, when another load is accepted in the writeback cycle.
- `T_RETIRE`: `S_LOAD_WAIT` to `S_IDLE`, when no load is accepted.
- `T_HOLD`: `S_IDLE` to `S_IDLE`, when no load is accepted.

Stores and base writebacks finish in the cycle of the request.

Top module: `ldst_index_agu`

## Requirements
- R1: In the cycle that an accepted request is presented, `mem_req` is 1 and `mem_addr` equals `b_val` plus either `a_val` or zero. Zero is used when `idx_a` is 0.
- R2: Operation codes on `req_op` are as follows. 0/1 is byte zero-extend, 2/3 is half zero-extend, 4/5 is half sign-extend, 6/7 is word load. 8/9 is byte, 10/11 is half, 12/13 is word store. An odd code is the with-update form. Codes 14 and 15, or `req_valid` low, produce no memory request, no base writeback and no later load writeback.
- R3: Byte lanes are big-endian: address offset 0 is `mem_be[3]` and data bits 31:24. Bytes use the single lane given by address bits 1:0. Halves use lanes 3:2 when address bit 1 is 0 and lanes 1:0 when it is 1. Words use all four lanes.
- R4: Store data places bits 7:0 of `s_val` (byte) or bits 15:0 (half) in the enabled lanes, in big-endian order. Word stores place all of `s_val`. Lanes that are not enabled are driven with zero.
- R5: A load asserts `ld_we` exactly one cycle after its request, with `ld_idx` equal to the `idx_d` of that request. No other cycle asserts `ld_we`.
- R6: Byte loads return the addressed lane zero-extended. Half zero-extend loads return the addressed half with the upper 16 bits cleared. Word loads return the whole read word.
- R7: Half sign-extend loads copy bit 15 of the addressed half into bits 31:16.
- R8: With-update forms assert `base_we` in the request cycle, with `base_idx` = `idx_a` and `base_data` = `mem_addr`. Plain forms never assert `base_we`.
- R9: A with-update load does not assert `base_we` when `idx_a` is 0 or `idx_a` equals `idx_d`. Its load writeback still takes place, so the loaded value is what reaches the destination.
- R10: A with-update store with `idx_a` = 0 still asserts `base_we` with `base_idx` = 0.
- R11: Loads may be accepted on consecutive cycles. Each writeback then carries its own index and its own data, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code (see R2) |
| idx_a | input | 5 | Base register index |
| idx_d | input | 5 | Destination (load) or source (store) register index |
| a_val | input | 32 | Value of base register |
| b_val | input | 32 | Value of index register |
| s_val | input | 32 | Store source register value |
| mem_rdata | input | 32 | Read word, valid one cycle after a load request |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Effective address |
| mem_be | output | 4 | Byte-lane enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Lane-aligned store data |
| ld_we | output | 1 | Load result writeback strobe |
| ld_idx | output | 5 | Load result register index |
| ld_data | output | 32 | Extended load result |
| base_we | output | 1 | Base register writeback strobe |
| base_idx | output | 5 | Base writeback register index |
| base_data | output | 32 | Base writeback value |

## Verification
The hardest situation to reach is a load writeback that overlaps a new request. In that cycle `ld_we` for the older load coincides with `mem_req`, and possibly `base_we`, of the next load, so the pending index and lane offset must not be overwritten early. The bench reaches it by issuing two loads on adjacent cycles, with different sizes, offsets and targets. Every operation code is also swept across all four address offsets and base/destination index pairs, which includes a zero base and a base equal to the destination.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [0:0] {
        S_IDLE      = 1'b0,
        S_LOAD_WAIT = 1'b1
    } ld_state_e;

    typedef struct packed {
        logic      valid;
        logic      store;
        logic      update;
        logic      sext;
        acc_size_e size;
    } op_info_t;

    // Operation codes: bit 0 selects the with-update form, bit 3 selects store.
    function automatic op_info_t decode_op(input logic [3:0] op);
        op_info_t r;
        r = '{valid: 1'b0, store: 1'b0, update: 1'b0, sext: 1'b0, size: SZ_BYTE};
        if (op <= 4'd13) begin
            r.valid  = 1'b1;
            r.store  = op[3];
            r.update = op[0];
            if (op[3]) begin
                r.size = acc_size_e'(op[2:1]);
            end else begin
                unique case (op[2:1])
                    2'd0: r.size = SZ_BYTE;
                    2'd1: r.size = SZ_HALF;
                    2'd2: begin
                        r.size = SZ_HALF;
                        r.sext = 1'b1;
                    end
                    default: r.size = SZ_WORD;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ldst_ea_gen.sv
module ldst_ea_gen #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input  logic [RIDX_W-1:0] idx_a,
    input  logic [XLEN-1:0]   a_val,
    input  logic [XLEN-1:0]   b_val,
    output logic [XLEN-1:0]   ea
);
    logic [XLEN-1:0] base_term;

    // Register index zero contributes zero, not its contents.
    assign base_term = (idx_a == '0) ? '0 : a_val;
    assign ea        = base_term + b_val;
endmodule

// File: rtl/ldst_base_upd.sv
module ldst_base_upd #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input  logic              fire,
    input  logic              is_store,
    input  logic              is_update,
    input  logic [RIDX_W-1:0] idx_a,
    input  logic [RIDX_W-1:0] idx_d,
    input  logic [XLEN-1:0]   ea,
    output logic              base_we,
    output logic [RIDX_W-1:0] base_idx,
    output logic [XLEN-1:0]   base_data
);
    logic load_ok;

    // Loads skip the base write when it would hit r0 or collide with the target.
    assign load_ok   = (idx_a != '0) && (idx_a != idx_d);
    assign base_we   = fire && is_update && (is_store || load_ok);
    assign base_idx  = idx_a;
    assign base_data = ea;
endmodule

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes import ldst_pkg::*; #(
    parameter int XLEN = 32
) (
    input  acc_size_e                     size,
    input  logic [$clog2(XLEN/8)-1:0]     off,
    input  logic [XLEN-1:0]               src,
    output logic [XLEN/8-1:0]             be,
    output logic [XLEN-1:0]               wdata
);
    localparam int NUM_LANES = XLEN / 8;
    localparam int LANE_W    = $clog2(NUM_LANES);

    for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
        // Lane j carries bits [8j+7:8j]; its big-endian byte offset is NUM_LANES-1-j.
        localparam logic [LANE_W-1:0] LANE_OFF = LANE_W'(NUM_LANES - 1 - j);
        logic       en;
        logic [7:0] byt;

        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    en  = (off == LANE_OFF);
                    byt = src[7:0];
                end
                SZ_HALF: begin
                    en  = (off[LANE_W-1:1] == LANE_OFF[LANE_W-1:1]);
                    byt = LANE_OFF[0] ? src[7:0] : src[15:8];
                end
                default: begin
                    en  = 1'b1;
                    byt = src[8*j +: 8];
                end
            endcase
        end

        assign be[j]          = en;
        assign wdata[8*j +: 8] = en ? byt : 8'h00;
    end
endmodule

// File: rtl/ldst_load_lanes.sv
module ldst_load_lanes import ldst_pkg::*; #(
    parameter int XLEN = 32
) (
    input  acc_size_e                 size,
    input  logic                      sext,
    input  logic [$clog2(XLEN/8)-1:0] off,
    input  logic [XLEN-1:0]           rdata,
    output logic [XLEN-1:0]           result
);
    localparam int NUM_LANES = XLEN / 8;
    localparam int LANE_W    = $clog2(NUM_LANES);

    logic [LANE_W+2:0] byte_pos;
    logic [LANE_W+2:0] half_pos;
    logic [7:0]        byte_sel;
    logic [15:0]       half_sel;

    // Offset k lives at bit 8*(NUM_LANES-1-k); the inverted offset gives that lane number.
    assign byte_pos = {~off, 3'b000};
    assign half_pos = {~off[LANE_W-1:1], 1'b0, 3'b000};
    assign byte_sel = rdata[byte_pos +: 8];
    assign half_sel = rdata[half_pos +: 16];

    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(XLEN-8){1'b0}}, byte_sel};
            SZ_HALF: result = sext ? {{(XLEN-16){half_sel[15]}}, half_sel}
                                   : {{(XLEN-16){1'b0}}, half_sel};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/ldst_index_agu.sv
module ldst_index_agu import ldst_pkg::*; #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [3:0]          req_op,
    input  logic [RIDX_W-1:0]   idx_a,
    input  logic [RIDX_W-1:0]   idx_d,
    input  logic [XLEN-1:0]     a_val,
    input  logic [XLEN-1:0]     b_val,
    input  logic [XLEN-1:0]     s_val,
    input  logic [XLEN-1:0]     mem_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [XLEN-1:0]     mem_addr,
    output logic [XLEN/8-1:0]   mem_be,
    output logic [XLEN-1:0]     mem_wdata,
    output logic                ld_we,
    output logic [RIDX_W-1:0]   ld_idx,
    output logic [XLEN-1:0]     ld_data,
    output logic                base_we,
    output logic [RIDX_W-1:0]   base_idx,
    output logic [XLEN-1:0]     base_data
);
    localparam int NUM_LANES = XLEN / 8;
    localparam int LANE_W    = $clog2(NUM_LANES);

    op_info_t              info;
    logic                  fire;
    logic                  issue_load;
    logic [XLEN-1:0]       ea;
    logic [NUM_LANES-1:0]  be_raw;
    logic [XLEN-1:0]       wdata_raw;

    ld_state_e             state_q, state_d;
    logic [RIDX_W-1:0]     pend_idx_q;
    logic [LANE_W-1:0]     pend_off_q;
    acc_size_e             pend_size_q;
    logic                  pend_sext_q;

    assign info       = decode_op(req_op);
    assign fire       = req_valid && info.valid;
    assign issue_load = fire && !info.store;

    ldst_ea_gen #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_ea (
        .idx_a (idx_a),
        .a_val (a_val),
        .b_val (b_val),
        .ea    (ea)
    );

    ldst_base_upd #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_base (
        .fire      (fire),
        .is_store  (info.store),
        .is_update (info.update),
        .idx_a     (idx_a),
        .idx_d     (idx_d),
        .ea        (ea),
        .base_we   (base_we),
        .base_idx  (base_idx),
        .base_data (base_data)
    );

    ldst_store_lanes #(.XLEN(XLEN)) u_st (
        .size  (info.size),
        .off   (ea[LANE_W-1:0]),
        .src   (s_val),
        .be    (be_raw),
        .wdata (wdata_raw)
    );

    ldst_load_lanes #(.XLEN(XLEN)) u_ld (
        .size   (pend_size_q),
        .sext   (pend_sext_q),
        .off    (pend_off_q),
        .rdata  (mem_rdata),
        .result (ld_data)
    );

    // Request-cycle memory outputs.
    assign mem_req   = fire;
    assign mem_we    = fire && info.store;
    assign mem_addr  = ea;
    assign mem_be    = fire ? be_raw : '0;
    assign mem_wdata = (fire && info.store) ? wdata_raw : '0;

    // Next state: T_ISSUE / T_CHAIN on a new load, T_RETIRE / T_HOLD otherwise.
    always_comb begin
        unique case (state_q)
            S_IDLE:      state_d = issue_load ? S_LOAD_WAIT : S_IDLE;
            S_LOAD_WAIT: state_d = issue_load ? S_LOAD_WAIT : S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Context of the load whose data returns next cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_idx_q  <= '0;
            pend_off_q  <= '0;
            pend_size_q <= SZ_BYTE;
            pend_sext_q <= 1'b0;
        end else if (issue_load) begin
            pend_idx_q  <= idx_d;
            pend_off_q  <= ea[LANE_W-1:0];
            pend_size_q <= info.size;
            pend_sext_q <= info.sext;
        end
    end

    // State-decoded outputs.
    always_comb begin
        ld_idx = pend_idx_q;
        unique case (state_q)
            S_IDLE:      ld_we = 1'b0;
            S_LOAD_WAIT: ld_we = 1'b1;
            default:     ld_we = 1'b0;
        endcase
    end
endmodule

// File: rtl/ldst_index_agu_chk.sv
module ldst_index_agu_chk #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [3:0]          req_op,
    input logic [RIDX_W-1:0]   idx_a,
    input logic [RIDX_W-1:0]   idx_d,
    input logic                mem_req,
    input logic                mem_we,
    input logic [XLEN-1:0]     mem_addr,
    input logic [XLEN/8-1:0]   mem_be,
    input logic [XLEN-1:0]     mem_wdata,
    input logic                ld_we,
    input logic [RIDX_W-1:0]   ld_idx,
    input logic                base_we,
    input logic [RIDX_W-1:0]   base_idx,
    input logic [XLEN-1:0]     base_data
);
    localparam int NUM_LANES = XLEN / 8;

    logic [XLEN-1:0] lane_mask;
    always_comb begin
        for (int j = 0; j < NUM_LANES; j++) begin
            lane_mask[8*j +: 8] = {8{mem_be[j]}};
        end
    end

    assert_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_op > 4'd13) |-> (!mem_req && !base_we));

    assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_op[2:1] == 2'd0) |-> ($countones(mem_be) == 1));

    assert_lane_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_wdata & ~lane_mask) == '0));

    assert_ld_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (ld_we && ld_idx == $past(idx_d)));

    assert_ld_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |-> $past(mem_req && !mem_we));

    assert_base_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |-> (mem_req && base_data == mem_addr && base_idx == idx_a));

    assert_load_suppress_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (base_we && !mem_we) |-> (idx_a != '0 && idx_a != idx_d));
endmodule

bind ldst_index_agu ldst_index_agu_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .idx_a     (idx_a),
    .idx_d     (idx_d),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .ld_we     (ld_we),
    .ld_idx    (ld_idx),
    .base_we   (base_we),
    .base_idx  (base_idx),
    .base_data (base_data)
);

// File: tb/ldst_index_agu_bench.sv
module ldst_index_agu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = 4'd0;
    logic [4:0]  idx_a = 5'd0;
    logic [4:0]  idx_d = 5'd0;
    logic [31:0] a_val = '0;
    logic [31:0] b_val = '0;
    logic [31:0] s_val = '0;
    logic [31:0] mem_rdata = '0;
    logic        mem_req, mem_we, ld_we, base_we;
    logic [31:0] mem_addr, mem_wdata, ld_data, base_data;
    logic [3:0]  mem_be;
    logic [4:0]  ld_idx, base_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ldst_index_agu u_ldst_index_agu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .idx_a(idx_a), .idx_d(idx_d), .a_val(a_val), .b_val(b_val), .s_val(s_val),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .ld_we(ld_we), .ld_idx(ld_idx),
        .ld_data(ld_data), .base_we(base_we), .base_idx(base_idx), .base_data(base_data)
    );

    function automatic logic [31:0] patt(input logic [31:0] addr);
        logic [7:0] s;
        s = addr[7:0] ^ addr[15:8];
        return {s ^ 8'h81, s ^ 8'h6E, s ^ 8'hF0, s ^ 8'h1F};
    endfunction

    // Memory model: read word returned one cycle after a read request.
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= patt(mem_addr);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ea_of(input int a, input logic [31:0] av, input logic [31:0] bv);
        return ((a == 0) ? 32'h0 : av) + bv;
    endfunction

    function automatic int size_of(input logic [3:0] o);
        if (o[3]) return int'(o[2:1]);
        return (o[2:1] == 2'd0) ? 0 : (o[2:1] == 2'd3) ? 2 : 1;
    endfunction

    function automatic logic [31:0] exp_load(input logic [3:0] o, input logic [31:0] ea);
        logic [31:0] rd;
        logic [15:0] h;
        int sz;
        rd = patt(ea);
        sz = size_of(o);
        h  = ea[1] ? rd[15:0] : rd[31:16];
        if (sz == 0) return (rd >> (8 * (3 - int'(ea[1:0])))) & 32'hFF;
        if (sz == 1) return (o[2:1] == 2'd2) ? {{16{h[15]}}, h} : {16'h0, h};
        return rd;
    endfunction

    // Present one request, check the request cycle, then the following cycle.
    task automatic run_one(input int op, input int a, input int d, input int off);
        logic [3:0]  o;
        logic [31:0] av, bv, sv, ea, wd;
        logic [3:0]  be;
        logic        vld, st, up, bwe;
        int          sz;
        o  = 4'(op);
        av = 32'h0001_2000 + 32'(a << 8);
        bv = 32'h0000_0040 + 32'(off);
        sv = 32'h9A8B_F17C;
        ea = ea_of(a, av, bv);
        vld = (op < 14);
        st  = o[3];
        up  = o[0];
        sz  = size_of(o);
        be  = (sz == 0) ? (4'b1000 >> off) : (sz == 1) ? (ea[1] ? 4'b0011 : 4'b1100) : 4'b1111;
        wd  = (sz == 0) ? ({24'h0, sv[7:0]} << (8 * (3 - off))) :
              (sz == 1) ? (ea[1] ? {16'h0, sv[15:0]} : {sv[15:0], 16'h0}) : sv;
        bwe = vld && up && (st || (a != 0 && a != d));

        @(negedge clk);
        req_valid = 1'b1; req_op = o; idx_a = 5'(a); idx_d = 5'(d);
        a_val = av; b_val = bv; s_val = sv;
        #1;
        if (!vld) begin
            chk("R2 mem_req on unused code", 32'(mem_req), 32'h0);
            chk("R2 base_we on unused code", 32'(base_we), 32'h0);
        end else begin
            chk("R1 mem_req", 32'(mem_req), 32'h1);
            chk("R1 mem_addr", mem_addr, ea);
            chk("R2 mem_we", 32'(mem_we), 32'(st));
            if (st) begin
                chk("R3 mem_be", 32'(mem_be), 32'(be));
                chk("R4 mem_wdata", mem_wdata, wd);
            end else begin
                chk("R3 load mem_be", 32'(mem_be), 32'(be));
            end
            if (up && !st)           chk("R9 base_we load", 32'(base_we), 32'(bwe));
            else if (up && a == 0)   chk("R10 base_we store r0", 32'(base_we), 32'(bwe));
            else                     chk("R8 base_we", 32'(base_we), 32'(bwe));
            if (bwe) begin
                chk("R8 base_idx", 32'(base_idx), 32'(a));
                chk("R8 base_data", base_data, ea);
            end
        end

        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (vld && !st) begin
            chk("R5 ld_we", 32'(ld_we), 32'h1);
            chk("R5 ld_idx", 32'(ld_idx), 32'(d));
            if (o[2:1] == 2'd2) chk("R7 ld_data sign", ld_data, exp_load(o, ea));
            else                chk("R6 ld_data", ld_data, exp_load(o, ea));
        end else begin
            chk("R5 no ld_we", 32'(ld_we), 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] ea1, ea2;
        repeat (3) @(negedge clk);
        #1;
        chk("R5 reset ld_we", 32'(ld_we), 32'h0);
        chk("R2 reset mem_req", 32'(mem_req), 32'h0);
        chk("R2 reset base_we", 32'(base_we), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Valid code with req_valid low has no effect (R2).
        @(negedge clk);
        req_valid = 1'b0; req_op = 4'd7; idx_a = 5'd4; idx_d = 5'd9;
        #1;
        chk("R2 idle mem_req", 32'(mem_req), 32'h0);
        chk("R2 idle base_we", 32'(base_we), 32'h0);
        @(negedge clk);
        #1;
        chk("R2 idle ld_we", 32'(ld_we), 32'h0);

        // Sweep every code, offset and index pairing.
        for (int op = 0; op < 16; op++)
            for (int off = 0; off < 4; off++)
                for (int a = 0; a < 8; a += 3)
                    for (int d = 3; d < 8; d += 3)
                        run_one(op, a, d, off);

        // Back-to-back loads (R11).
        @(negedge clk);
        req_valid = 1'b1; req_op = 4'd5; idx_a = 5'd5; idx_d = 5'd6;
        a_val = 32'h0003_0F00; b_val = 32'h0000_0012;
        ea1 = a_val + b_val;
        #1;
        chk("R11 first request", mem_addr, ea1);
        @(negedge clk);
        req_op = 4'd0; idx_a = 5'd0; idx_d = 5'd9;
        a_val = 32'hFFFF_0000; b_val = 32'h0000_3A01;
        ea2 = b_val;
        #1;
        chk("R11 second request", mem_addr, ea2);
        chk("R11 first ld_we", 32'(ld_we), 32'h1);
        chk("R11 first ld_idx", 32'(ld_idx), 32'd6);
        chk("R11 first ld_data", ld_data, exp_load(4'd5, ea1));
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R11 second ld_we", 32'(ld_we), 32'h1);
        chk("R11 second ld_idx", 32'(ld_idx), 32'd9);
        chk("R11 second ld_data", ld_data, exp_load(4'd0, ea2));
        @(negedge clk);
        #1;
        chk("R5 pipeline drained", 32'(ld_we), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule